// File: doc/BRIEF.md
# Capture Address Register Bank

This block holds the frame-buffer addresses that a video capture engine writes into. There is one base address for odd fields and one for even fields. There is also one chroma (U-plane) offset for each field parity. Software programs them over a small register bus with byte offsets. A write to either base does not touch the address the engine is using. The new value waits in a shadow copy, and a status bit reports that a change is waiting.

When the capture engine reports the first data word of a field, every shadow base moves into its active register in the same clock edge, and the status bit drops. The parity of the field is latched when the field starts. It picks which active base drives the write-start output and which chroma offset is added to form the U-plane start. Field-start and first-data strobes come from the capture logic outside the block.

Top module: `cap_addr_regs`

## Requirements
- R1: A write to a base register (even base at byte offset 0x00, odd base at 0x04) changes only its shadow copy. `active_base` keeps its value until a `first_data` commit or a parity change at `field_start`.
- R2: Any write to either base register sets the waiting flag: `upd_pending` becomes 1 after that edge, and bit 0 of the status register at offset 0x10 reads 1.
- R3: On a clock edge with `first_data` high, both shadow bases are copied into the active bases together. If no base write happens on that same edge, `upd_pending` clears to 0.
- R4: Base values have bits [3:0] forced to zero on write, so reads and active values are 16-byte aligned.
- R5: The chroma offsets (even at 0x08, odd at 0x0C) take the write directly, with bits [3:0] and bit [4] forced to zero (32-byte aligned).
- R6: `u_start` equals `active_base` plus the chroma offset for the latched parity, modulo 2^32.
- R7: Under reset every register is 0. `active_base`, `u_start`, `upd_pending` and every readable register read 0.
- R8: `field_is_odd` is sampled only on a cycle with `field_start` high. A latched 1 selects the odd base and odd offset, and a latched 0 selects the even pair. The selection holds until the next `field_start`.
- R9: If a base write and `first_data` fall on the same edge, the previous shadow value is committed, the newly written value stays in the shadow, and `upd_pending` stays 1.
- R10: Reading a base register returns its shadow value, not the active one.
- R11: Reads of unmapped offsets return 0, and writes to the status register or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Single-cycle write strobe |
| reg_addr | input | AW (5) | Byte offset of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| field_start | input | 1 | Start-of-field strobe; latches parity |
| field_is_odd | input | 1 | Parity of the starting field |
| first_data | input | 1 | First captured data of a field; commit strobe |
| active_base | output | DATA_W (32) | Active write base for the latched parity |
| u_start | output | DATA_W (32) | U-plane start address |
| upd_pending | output | 1 | Shadow bases waiting for commit |

## Verification
The assertions assume that the strobe inputs are clean single-bit levels sampled at the rising edge. They also assume that `active_base` can move only after a `first_data` or `field_start` edge, so any other cause of change is treated as an error. The bench drives every input on the falling edge, so each strobe is seen by exactly one rising edge. It also never raises `field_start` and `first_data` together except where the test aims at that case. The same-edge write-plus-commit case is driven on purpose and checked through the readback and the active output.

// File: rtl/cap_addr_pkg.sv
// Shared constants for the capture address register bank.
// Assumes a byte-addressed bus with 32-bit registers on a 4-byte stride.
package cap_addr_pkg;
    localparam int unsigned N_PARITY   = 2;     // index 0 = even field, 1 = odd field
    localparam int unsigned REG_STRIDE = 4;
    localparam int unsigned OFF_BASE0  = 'h00;  // even base, odd base follows
    localparam int unsigned OFF_UOFF0  = 'h08;  // even U offset, odd U offset follows
    localparam int unsigned OFF_STATUS = 'h10;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } parity_e;
endpackage

// File: rtl/cap_shadow_reg.sv
// One double-buffered address register: a software-visible shadow copy
// and an active copy loaded from the shadow on commit.
// Assumes wr_en and commit are single-cycle strobes; on a shared edge the
// old shadow value is committed and the new write lands in the shadow.
module cap_shadow_reg #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LSB    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] shadow_q,
    output logic [DATA_W-1:0] active_q
);
    localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << LSB) - DATA_W'(1));

    // Shadow copy: takes every aligned software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_en)
            shadow_q <= wdata & ALIGN_MASK;
    end

    // Active copy: loads the pre-edge shadow value on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (commit)
            active_q <= shadow_q;
    end
endmodule

// File: rtl/cap_reg_decode.sv
// Register bus decoder: turns a byte offset and write strobe into per-register
// write enables, and muxes the read data combinationally.
// Assumes word-aligned offsets; anything not mapped reads zero.
module cap_reg_decode
    import cap_addr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 5
) (
    input  logic                              wr_en,
    input  logic [AW-1:0]                     addr,
    input  logic [N_PARITY-1:0][DATA_W-1:0]   base_shadow,
    input  logic [N_PARITY-1:0][DATA_W-1:0]   uoff,
    input  logic                              pending,
    output logic [N_PARITY-1:0]               base_we,
    output logic [N_PARITY-1:0]               uoff_we,
    output logic [DATA_W-1:0]                 rdata
);
    // Write enables for each mapped register.
    always_comb begin
        for (int i = 0; i < N_PARITY; i++) begin
            base_we[i] = wr_en && (addr == AW'(OFF_BASE0 + REG_STRIDE * i));
            uoff_we[i] = wr_en && (addr == AW'(OFF_UOFF0 + REG_STRIDE * i));
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PARITY; i++) begin
            if (addr == AW'(OFF_BASE0 + REG_STRIDE * i)) rdata = base_shadow[i];
            if (addr == AW'(OFF_UOFF0 + REG_STRIDE * i)) rdata = uoff[i];
        end
        if (addr == AW'(OFF_STATUS)) rdata = DATA_W'(pending);
    end
endmodule

// File: rtl/cap_addr_sel.sv
// Parity select and chroma adder: latches field parity at field start and
// forms the active base and the U-plane start address from it.
// Assumes field_is_odd is valid on the cycle field_start is high.
module cap_addr_sel
    import cap_addr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            field_start,
    input  logic                            field_is_odd,
    input  logic [N_PARITY-1:0][DATA_W-1:0] act_base,
    input  logic [N_PARITY-1:0][DATA_W-1:0] uoff,
    output logic [DATA_W-1:0]               base_out,
    output logic [DATA_W-1:0]               u_out
);
    parity_e parity_q;

    // Latch parity of the field being captured.
    always_ff @(posedge clk) begin
        if (!rst_n)
            parity_q <= PAR_EVEN;
        else if (field_start)
            parity_q <= field_is_odd ? PAR_ODD : PAR_EVEN;
    end

    // Select base and add chroma offset of the same parity.
    always_comb begin
        base_out = act_base[parity_q];
        u_out    = act_base[parity_q] + uoff[parity_q];
    end
endmodule

// File: rtl/cap_addr_regs.sv
// Top of the capture address register bank. Holds double-buffered field
// bases, direct chroma offsets and the commit-waiting flag.
// Assumes first_data pulses once on the first captured word of each field.
module cap_addr_regs
    import cap_addr_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned AW       = 5,
    parameter int unsigned BASE_LSB = 4,
    parameter int unsigned UOFF_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              field_start,
    input  logic              field_is_odd,
    input  logic              first_data,
    output logic [DATA_W-1:0] active_base,
    output logic [DATA_W-1:0] u_start,
    output logic              upd_pending
);
    localparam logic [DATA_W-1:0] UOFF_MASK = ~((DATA_W'(1) << UOFF_LSB) - DATA_W'(1));

    logic [N_PARITY-1:0]             base_we;
    logic [N_PARITY-1:0]             uoff_we;
    logic [N_PARITY-1:0][DATA_W-1:0] base_shadow;
    logic [N_PARITY-1:0][DATA_W-1:0] base_active;
    logic [N_PARITY-1:0][DATA_W-1:0] uoff_q;
    logic                            pending_q;

    cap_reg_decode #(.DATA_W(DATA_W), .AW(AW)) u_dec (
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .base_shadow (base_shadow),
        .uoff        (uoff_q),
        .pending     (pending_q),
        .base_we     (base_we),
        .uoff_we     (uoff_we),
        .rdata       (reg_rdata)
    );

    for (genvar g = 0; g < N_PARITY; g++) begin : g_par
        cap_shadow_reg #(.DATA_W(DATA_W), .LSB(BASE_LSB)) u_base (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (base_we[g]),
            .wdata    (reg_wdata),
            .commit   (first_data),
            .shadow_q (base_shadow[g]),
            .active_q (base_active[g])
        );

        // Chroma offset: direct register, 32-byte aligned.
        always_ff @(posedge clk) begin
            if (!rst_n)
                uoff_q[g] <= '0;
            else if (uoff_we[g])
                uoff_q[g] <= reg_wdata & UOFF_MASK;
        end
    end

    // Waiting flag: set by any base write, cleared by a commit without one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (|base_we)
            pending_q <= 1'b1;
        else if (first_data)
            pending_q <= 1'b0;
    end

    cap_addr_sel #(.DATA_W(DATA_W)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_start  (field_start),
        .field_is_odd (field_is_odd),
        .act_base     (base_active),
        .uoff         (uoff_q),
        .base_out     (active_base),
        .u_out        (u_start)
    );

    assign upd_pending = pending_q;
endmodule

// File: rtl/cap_addr_regs_chk.sv
// Property checker for the capture address register bank, bound to the top.
// Assumes strobes are sampled at the rising edge after reset release.
module cap_addr_regs_chk
    import cap_addr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [AW-1:0]     reg_addr,
    input logic              field_start,
    input logic              first_data,
    input logic [DATA_W-1:0] active_base,
    input logic [DATA_W-1:0] u_start,
    input logic              upd_pending
);
    logic base_wr;
    assign base_wr = reg_wr_en &&
                     ((reg_addr == AW'(OFF_BASE0)) || (reg_addr == AW'(OFF_BASE0 + REG_STRIDE)));

    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> upd_pending);

    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_data && !base_wr) |=> !upd_pending);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pending && !first_data) |=> upd_pending);

    p_base_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_data && !field_start) |=> $stable(active_base));

    p_base_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active_base[3:0] == 4'h0);

    p_uoff_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        u_start[4:0] == active_base[4:0]);
endmodule

bind cap_addr_regs cap_addr_regs_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .field_start (field_start),
    .first_data  (first_data),
    .active_base (active_base),
    .u_start     (u_start),
    .upd_pending (upd_pending)
);

// File: tb/cap_addr_regs_test.sv
// Self-checking bench: register write/readback table, then directed tests.
module cap_addr_regs_test;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr_en;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic          field_start;
    logic          field_is_odd;
    logic          first_data;
    logic [DW-1:0] active_base;
    logic [DW-1:0] u_start;
    logic          upd_pending;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cap_addr_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .field_start(field_start),
        .field_is_odd(field_is_odd), .first_data(first_data),
        .active_base(active_base), .u_start(u_start), .upd_pending(upd_pending)
    );

    // {addr, write data, expected readback after write}
    localparam logic [AW+2*DW-1:0] TBL [0:7] = '{
        {5'h00, 32'h12345678, 32'h12345670},  // R4 even base aligned, R10
        {5'h04, 32'hABCDEF0F, 32'hABCDEF00},  // R4 odd base aligned, R10
        {5'h08, 32'h000012FF, 32'h000012E0},  // R5 even U offset
        {5'h0C, 32'h0000403F, 32'h00004020},  // R5 odd U offset
        {5'h10, 32'hFFFFFFFF, 32'h00000001},  // R11 status write ignored, R2 set
        {5'h14, 32'hDEADBEEF, 32'h00000000},  // R11 unmapped
        {5'h1C, 32'hCAFEF00D, 32'h00000000},  // R11 unmapped
        {5'h00, 32'h0000100F, 32'h00001000}   // R10 even base rewritten
    };

    task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_first();
        @(negedge clk); first_data = 1'b1;
        @(negedge clk); first_data = 1'b0;
    endtask

    task automatic start_field(input logic odd);
        @(negedge clk); field_start = 1'b1; field_is_odd = odd;
        @(negedge clk); field_start = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] rd;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        field_start = 1'b0; field_is_odd = 1'b0; first_data = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state
        check(active_base, 32'h0, "R7 active_base after reset");
        check(u_start, 32'h0, "R7 u_start after reset");
        check({31'b0, upd_pending}, 32'h0, "R7 upd_pending after reset");
        for (int a = 0; a < 5; a++) begin
            bus_read(AW'(a * 4), rd);
            check(rd, 32'h0, "R7 register reads zero after reset");
        end

        // Table walk: write then read back
        for (int i = 0; i < 8; i++) begin
            bus_write(TBL[i][AW+2*DW-1:2*DW], TBL[i][2*DW-1:DW]);
            bus_read(TBL[i][AW+2*DW-1:2*DW], rd);
            check(rd, TBL[i][DW-1:0], "R4/R5/R10/R11 table readback");
        end

        // R1 / R2: shadow writes leave active untouched, flag set
        check(active_base, 32'h0, "R1 active unchanged before commit");
        check({31'b0, upd_pending}, 32'h1, "R2 upd_pending set");
        start_field(1'b0);
        check(active_base, 32'h0, "R1 field_start alone does not commit");

        // R3 / R6: commit on first data, even field
        pulse_first();
        check(active_base, 32'h00001000, "R3 even base committed");
        check(u_start, 32'h000022E0, "R6 even u_start");
        check({31'b0, upd_pending}, 32'h0, "R3 upd_pending cleared");
        bus_read(5'h10, rd);
        check(rd, 32'h0, "R3 status register cleared");

        // R8 / R3: odd field uses odd base committed on the same edge
        start_field(1'b1);
        check(active_base, 32'hABCDEF00, "R8/R3 odd base selected");
        check(u_start, 32'hABCE2F20, "R6/R8 odd u_start uses odd offset");
        @(negedge clk); field_is_odd = 1'b0;
        @(negedge clk);
        check(active_base, 32'hABCDEF00, "R8 parity held without field_start");

        // R9: write and commit on the same edge
        bus_write(5'h04, 32'h00007770);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h00005550; first_data = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; first_data = 1'b0;
        check(active_base, 32'h00007770, "R9 previous shadow committed");
        check({31'b0, upd_pending}, 32'h1, "R9 upd_pending stays set");
        bus_read(5'h04, rd);
        check(rd, 32'h00005550, "R9 new value remains in shadow");
        pulse_first();
        check(active_base, 32'h00005550, "R9 later commit takes new value");
        check({31'b0, upd_pending}, 32'h0, "R9 flag cleared after later commit");

        // R6 wrap-around of the U-plane adder
        bus_write(5'h04, 32'hFFFFFFF0);
        bus_write(5'h0C, 32'h00000040);
        pulse_first();
        check(u_start, 32'h00000030, "R6 u_start wraps modulo 2^32");

        // R7 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(active_base, 32'h0, "R7 active_base cleared by reset");
        check({31'b0, upd_pending}, 32'h0, "R7 flag cleared by reset");
        bus_read(5'h0C, rd);
        check(rd, 32'h0, "R7 U offset cleared by reset");
        rst_n = 1'b1;

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule